// File: doc/BRIEF.md
# Dual-Mode Programmable Feedback Divider

This block sits in the feedback path of a frequency-synthesizer loop. It counts events of a local-oscillator signal and emits one pulse every N events, where N is a divisor written through a parallel control word. The pulse goes to a phase comparator outside the block. Both oscillator inputs arrive as single-cycle event strobes on the block clock: one for a high-band oscillator and one for a low-band oscillator.

Two mode bits pick one of three division paths, and each path has its own legal divisor range. The high-band path divides its input by two first and then feeds a dual-modulus swallow counter. The low-band path feeds either the same swallow counter directly or a plain 12-bit down counter. The swallow counter models a 16/17 prescaler. The low four bits of N set how many prescaler cycles run at modulus 17, and the remaining upper bits set the total number of prescaler cycles.

A control word is checked when it is loaded. A legal word waits as pending and takes over only at the next terminal count, so a division cycle that is already running is never cut short. An illegal word raises an error flag and is dropped, and the last legal divisor stays in force.

Top module: `fb_divider`

## Requirements
- R1: With `bandSel`=1 the divider issues one pulse per 2×`divisorIn` events on `hiEdge` (divide-by-two followed by the swallow counter).
- R2: With `bandSel`=1 a value from 272 to 65535 is legal. A value below 272 sets `cfgError`.
- R3: With `bandSel`=0 and `senseSel`=1 the divider issues one pulse per `divisorIn` events on `loEdge`. Values 272 to 65535 are legal, and a value below 272 sets `cfgError`.
- R4: With `bandSel`=0 and `senseSel`=0 the divider issues one pulse per `divisorIn` events on `loEdge`. Values 5 to 4095 are legal, and values below 5 or above 4095 set `cfgError`.
- R5: Mode encoding is `bandSel`=1 for high band, {0,1} for low-band swallow and {0,0} for direct. Events on the input that the active mode does not use have no effect on the pulse spacing.
- R6: In swallow modes bits [3:0] of the divisor are the count of modulus-17 prescaler cycles and bits [15:4] are the total count of prescaler cycles. The division is exact for any low-bit value.
- R7: A legal load takes effect at the next terminal count. The division cycle in progress completes with the previous divisor and mode.
- R8: `cfgError` is updated one cycle after `loadStrobe`: 1 for an illegal word, which is discarded while the last legal setting stays active, and 0 for a legal word. Without a load it holds its value.
- R9: `divPulse` is high for exactly one clock cycle, in the cycle after the input event that completes a division cycle.
- R10: Synchronous `rst` clears all counters and `cfgError`, drives `divPulse` low, and selects direct mode with divisor 4095. The first cycle after reset therefore spans 4095 `loEdge` events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bandSel | input | 1 | Mode bit: 1 selects the high-band path |
| senseSel | input | 1 | Mode bit for the low band: 1 selects swallow mode, 0 selects direct mode |
| loadStrobe | input | 1 | Loads the mode bits and `divisorIn` |
| divisorIn | input | 16 | Programmed divisor value |
| hiEdge | input | 1 | One-cycle event strobe from the high-band oscillator |
| loEdge | input | 1 | One-cycle event strobe from the low-band oscillator |
| divPulse | output | 1 | One-cycle pulse at the end of each division cycle |
| cfgError | output | 1 | Set when the last loaded word was illegal |

## Verification
The two event inputs are gated by independent pseudo-random patterns. This shows whether the divider counts only the selected input and whether it handles gaps in the events. A later phase drives an event on every clock, which shows whether back-to-back terminal counts reload correctly at the minimum spacing. The test divisors are the minimum legal value in each mode and values whose low four bits are non-zero. These separate a correct modulus-17 and modulus-16 mix from a plain 16×M count. Loads placed in the middle of a division cycle, with values just outside the limits and with the maximum high-band value, show whether a change waits for the terminal count and whether a rejected word leaves the running divisor unchanged.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  // Divisor word width, swallow-field width and direct-counter width.
  localparam int DivW      = 16;
  localparam int SwallowW  = 4;
  localparam int DirectW   = 12;
  localparam int DirectMin = 5;

  // Derived limits: the swallow minimum is (2^S + 1) * 2^S.
  localparam int PreMod     = 1 << SwallowW;
  localparam int SwallowMin = (PreMod + 1) * PreMod;
  localparam int DirectMax  = (1 << DirectW) - 1;

  typedef enum logic [1:0] {
    MODE_DIRECT       = 2'd0,
    MODE_LOW_SWALLOW  = 2'd1,
    MODE_HIGH_SWALLOW = 2'd2
  } divModeE;

  typedef struct packed {
    divModeE           mode;
    logic [DivW-1:0]   value;
  } divCfgT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic countEvent;   // one counted input event this cycle
    logic swallowMode;  // active mode uses the dual-modulus counter
  } dpStrobeT;
endpackage

// File: rtl/fbdiv_ctrl.sv
module fbdiv_ctrl
  import fbdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            bandSel,
  input  logic            senseSel,
  input  logic            loadStrobe,
  input  logic [DivW-1:0] divisorIn,
  input  logic            hiEdge,
  input  logic            loEdge,
  input  logic            terminal,
  output dpStrobeT        strobes,
  output logic [DivW-1:0] reloadValue,
  output logic            cfgError
);
  localparam divCfgT ResetCfg = '{mode: MODE_DIRECT, value: DivW'(DirectMax)};

  divCfgT  requestCfg;
  divCfgT  pendingCfg;
  divModeE activeMode;
  logic    requestLegal;
  logic    halfPhase;

  // Decode the mode bits of the incoming control word.
  always_comb begin
    requestCfg.value = divisorIn;
    if (bandSel)       requestCfg.mode = MODE_HIGH_SWALLOW;
    else if (senseSel) requestCfg.mode = MODE_LOW_SWALLOW;
    else               requestCfg.mode = MODE_DIRECT;
  end

  // Each mode has its own legal range.
  always_comb begin
    case (requestCfg.mode)
      MODE_DIRECT:
        requestLegal = (divisorIn >= DivW'(DirectMin)) &&
                       (divisorIn <= DivW'(DirectMax));
      default:
        requestLegal = (divisorIn >= DivW'(SwallowMin));
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingCfg <= ResetCfg;
      activeMode <= MODE_DIRECT;
      halfPhase  <= 1'b0;
      cfgError   <= 1'b0;
    end else begin
      if (loadStrobe) begin
        if (requestLegal) pendingCfg <= requestCfg;
        cfgError <= !requestLegal;
      end
      if (terminal) begin
        activeMode <= pendingCfg.mode;
        halfPhase  <= 1'b0;
      end else if (activeMode == MODE_HIGH_SWALLOW && hiEdge) begin
        halfPhase <= !halfPhase;
      end
    end
  end

  // The high band counts every second event (fixed divide-by-two).
  always_comb begin
    strobes.countEvent  = (activeMode == MODE_HIGH_SWALLOW) ? (hiEdge && halfPhase)
                                                            : loEdge;
    strobes.swallowMode = (activeMode != MODE_DIRECT);
    reloadValue         = pendingCfg.value;
  end
endmodule

// File: rtl/fbdiv_datapath.sv
module fbdiv_datapath
  import fbdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  dpStrobeT        strobes,
  input  logic [DivW-1:0] reloadValue,
  output logic            terminal,
  output logic            divPulse
);
  localparam int MainW = DivW - SwallowW;
  localparam int PreW  = SwallowW + 1;
  localparam logic [PreW-1:0] TopMod16 = PreW'(PreMod - 1);
  localparam logic [PreW-1:0] TopMod17 = PreW'(PreMod);

  logic [DirectW-1:0]  directLeft;
  logic [PreW-1:0]     preCount;
  logic [SwallowW-1:0] swallowLeft;
  logic [MainW-1:0]    mainLeft;
  logic                preWrap;
  logic                directDone;
  logic                swallowDone;

  // The prescaler runs at modulus 17 until the swallow count is spent.
  always_comb begin
    preWrap     = (preCount == ((swallowLeft != '0) ? TopMod17 : TopMod16));
    directDone  = (directLeft == '0);
    swallowDone = preWrap && (mainLeft == MainW'(1));
    terminal    = strobes.countEvent &&
                  (strobes.swallowMode ? swallowDone : directDone);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      directLeft  <= DirectW'(DirectMax - 1);
      preCount    <= '0;
      swallowLeft <= SwallowW'(DirectMax);
      mainLeft    <= MainW'(DirectMax >> SwallowW);
      divPulse    <= 1'b0;
    end else begin
      divPulse <= terminal;
      if (terminal) begin
        directLeft  <= DirectW'(reloadValue - DivW'(1));
        preCount    <= '0;
        swallowLeft <= reloadValue[SwallowW-1:0];
        mainLeft    <= reloadValue[DivW-1:SwallowW];
      end else if (strobes.countEvent) begin
        if (strobes.swallowMode) begin
          if (preWrap) begin
            preCount <= '0;
            mainLeft <= mainLeft - MainW'(1);
            if (swallowLeft != '0) swallowLeft <= swallowLeft - SwallowW'(1);
          end else begin
            preCount <= preCount + PreW'(1);
          end
        end else begin
          directLeft <= directLeft - DirectW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fb_divider.sv
module fb_divider
  import fbdiv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            bandSel,
  input  logic            senseSel,
  input  logic            loadStrobe,
  input  logic [DivW-1:0] divisorIn,
  input  logic            hiEdge,
  input  logic            loEdge,
  output logic            divPulse,
  output logic            cfgError
);
  dpStrobeT        strobes;
  logic [DivW-1:0] reloadValue;
  logic            terminal;

  fbdiv_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .bandSel    (bandSel),
    .senseSel   (senseSel),
    .loadStrobe (loadStrobe),
    .divisorIn  (divisorIn),
    .hiEdge     (hiEdge),
    .loEdge     (loEdge),
    .terminal   (terminal),
    .strobes    (strobes),
    .reloadValue(reloadValue),
    .cfgError   (cfgError)
  );

  fbdiv_datapath u_datapath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .reloadValue(reloadValue),
    .terminal   (terminal),
    .divPulse   (divPulse)
  );
endmodule

// File: rtl/fb_divider_checker.sv
module fb_divider_checker
  import fbdiv_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            bandSel,
  input logic            senseSel,
  input logic            loadStrobe,
  input logic [DivW-1:0] divisorIn,
  input logic            hiEdge,
  input logic            loEdge,
  input logic            divPulse,
  input logic            cfgError
);
  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse);

  assert_pulse_from_event_R5: assert property (@(posedge clk) disable iff (rst)
    divPulse |-> $past(hiEdge || loEdge));

  assert_direct_over_R4: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && !bandSel && !senseSel && divisorIn > DivW'(DirectMax)) |=> cfgError);

  assert_high_under_R2: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && bandSel && divisorIn < DivW'(SwallowMin)) |=> cfgError);

  assert_low_swallow_ok_R3: assert property (@(posedge clk) disable iff (rst)
    (loadStrobe && !bandSel && senseSel && divisorIn >= DivW'(SwallowMin)) |=> !cfgError);

  assert_error_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !loadStrobe |=> $stable(cfgError));

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!divPulse && !cfgError));
endmodule

bind fb_divider fb_divider_checker u_fb_divider_checker (
  .clk       (clk),
  .rst       (rst),
  .bandSel   (bandSel),
  .senseSel  (senseSel),
  .loadStrobe(loadStrobe),
  .divisorIn (divisorIn),
  .hiEdge    (hiEdge),
  .loEdge    (loEdge),
  .divPulse  (divPulse),
  .cfgError  (cfgError)
);

// File: tb/fb_divider_bench.sv
module fb_divider_bench;
  import fbdiv_pkg::*;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bandSel = 1'b0;
  logic            senseSel = 1'b0;
  logic            loadStrobe = 1'b0;
  logic [DivW-1:0] divisorIn = '0;
  logic            hiEdge = 1'b0;
  logic            loEdge = 1'b0;
  logic            divPulse;
  logic            cfgError;

  always #10 clk = ~clk;  // 50 MHz

  fb_divider u_fb_divider (
    .clk(clk), .rst(rst), .bandSel(bandSel), .senseSel(senseSel),
    .loadStrobe(loadStrobe), .divisorIn(divisorIn), .hiEdge(hiEdge),
    .loEdge(loEdge), .divPulse(divPulse), .cfgError(cfgError)
  );

  typedef struct {
    int unsigned events;
    bit          onHigh;
    int          req;
  } expectT;

  expectT      expq[$];
  expectT      steady;
  int          checks = 0;
  int          failures = 0;
  int          pulsesSeen = 0;
  int unsigned hiCount = 0;
  int unsigned loCount = 0;
  bit          prevPulse = 1'b0;
  bit          dense = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(bit ok, int req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Event generator: independent pseudo-random gating, or every cycle.
  initial begin
    wait (!rst);
    forever begin
      @(posedge clk); #1;
      lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hiEdge = dense | lfsr[0];
      loEdge = dense | lfsr[5];
    end
  end

  // Monitor: counts events per input and scores each pulse (R1 R3 R4 R6 R7 R9 R10).
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        hiCount = 0;
        loCount = 0;
        prevPulse = 1'b0;
      end else begin
        if (divPulse) begin
          expectT e;
          int unsigned act;
          if (expq.size() != 0) e = expq.pop_front();
          else                  e = steady;
          act = e.onHigh ? hiCount : loCount;
          check(act == e.events, e.req, "events per division cycle", act, e.events);
          check(!prevPulse, 9, "pulse width one cycle", prevPulse, 0);  // R9
          hiCount = 0;
          loCount = 0;
          pulsesSeen++;
        end
        prevPulse = divPulse;
        if (hiEdge) hiCount++;
        if (loEdge) loCount++;
      end
    end
  end

  task automatic waitPulses(int n);
    int target = pulsesSeen + n;
    while (pulsesSeen < target) @(posedge clk);
  endtask

  task automatic loadCfg(bit band, bit sense, int unsigned value);
    @(posedge clk); #2;
    bandSel = band; senseSel = sense; divisorIn = DivW'(value); loadStrobe = 1'b1;
    @(posedge clk); #2;
    loadStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic errLoad(bit band, bit sense, int unsigned value, int req);
    loadCfg(band, sense, value);
    check(cfgError == 1'b1, req, "illegal word flags error", cfgError, 1);
  endtask

  // The cycle in progress keeps the old setting (R7); then the new one runs.
  task automatic runPhase(bit band, bit sense, int unsigned value, int reps, int req, bit sync);
    if (sync) waitPulses(1);
    expq.push_back('{events: steady.events, onHigh: steady.onHigh, req: 7});
    loadCfg(band, sense, value);
    check(cfgError == 1'b0, 8, "legal word clears error", cfgError, 0);  // R8
    steady = '{events: band ? 2 * value : value, onHigh: band, req: req};
    waitPulses(reps);
  endtask

  initial begin
    steady = '{events: 4095, onHigh: 1'b0, req: 10};  // R10 reset divisor
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(divPulse == 1'b0, 10, "reset divPulse", divPulse, 0);   // R10
    check(cfgError == 1'b0, 10, "reset cfgError", cfgError, 0);   // R10

    runPhase(1'b0, 1'b0, 5, 3, 4, 1'b0);       // R4 direct minimum
    errLoad(1'b0, 1'b0, 4, 8);                 // R8 below direct minimum
    errLoad(1'b0, 1'b0, 4096, 4);              // R4 above 12-bit range
    runPhase(1'b0, 1'b1, 272, 2, 3, 1'b1);     // R3 low swallow minimum
    errLoad(1'b0, 1'b1, 271, 3);               // R3 below swallow minimum
    runPhase(1'b0, 1'b1, 1000, 2, 6, 1'b1);    // R6 low bits 8

    // High band, R1 R2: maximum accepted, then 273 overrides it before the terminal count.
    waitPulses(1);
    expq.push_back('{events: steady.events, onHigh: steady.onHigh, req: 7});
    loadCfg(1'b1, 1'b0, 65535);
    check(cfgError == 1'b0, 2, "high band maximum legal", cfgError, 0);
    loadCfg(1'b1, 1'b0, 273);
    check(cfgError == 1'b0, 2, "high band 273 legal", cfgError, 0);
    steady = '{events: 546, onHigh: 1'b1, req: 1};
    waitPulses(2);
    errLoad(1'b1, 1'b0, 100, 2);               // R2 rejected, 546 held

    dense = 1'b1;
    runPhase(1'b0, 1'b0, 17, 3, 5, 1'b1);      // R5 back to low band, dense events

    // Mid-run reset, R10: error set first, then cleared by reset.
    errLoad(1'b0, 1'b0, 3, 8);
    @(posedge clk); #2 rst = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst = 1'b0;
    expq.delete();
    steady = '{events: 4095, onHigh: 1'b0, req: 10};
    @(negedge clk);
    check(cfgError == 1'b0, 10, "cfgError after reset", cfgError, 0);
    check(divPulse == 1'b0, 10, "divPulse after reset", divPulse, 0);
    waitPulses(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(150000 * 20);
    checks++;
    failures++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", pulsesSeen, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule